// File: doc/BRIEF.md
# Interruptible Push-Multiple Sequencer

This block carries out a decrement-before store of several registers onto a descending stack. A start strobe supplies a base pointer and a register-selection mask. The sequencer then reads the selected registers one at a time through a register-file read port. It writes each one to the next lower word below the base. When the last word has been accepted, it issues a single stack-pointer update.

Two operating modes are supported. In standard mode the transfer runs to completion, and only a synchronous memory abort can cut it short. In low-latency mode, an interrupt request or an asynchronous abort stops the transfer between word writes. An interrupted transfer is normally restarted from its first word, so words already stored are written a second time. When continuation is enabled, an interrupt stop instead records the remaining mask and the next address in a resume register. A resume strobe then picks the transfer up from that register.

Top module: `push_multiple_seq`

## Requirements
- R1: For mask bit i selecting register i, a transfer of N selected registers writes N words, the first at base−4 and each following accepted write exactly 4 bytes lower, ending at base−4N.
- R2: Registers are written from the highest-numbered selected register down to the lowest, so lower-numbered registers land at lower addresses; the written data is the register-file value returned for the index presented in the same cycle.
- R3: One cycle after the last accepted word, `done` pulses with `sp_we` high and `sp_wdata` = base−4N; `sp_we` is never raised at any other time.
- R4: With `mode_lowlat`=0, `irq` and `async_abort` have no effect: every selected word is written and the pointer update occurs.
- R5: With `mode_lowlat`=1, a high `irq` during a transfer cycle suppresses the write of that cycle, `abandoned` pulses the next cycle, no pointer update is made and the block returns to idle.
- R6: With `cont_en`=0, after an interrupt stop the resume register still holds the original mask and base−4, and a `resume` strobe rewrites every selected word from the top, repeating earlier writes.
- R7: With `cont_en`=1, an interrupt stop saves the not-yet-written mask and the next address; `resume` then writes only those registers, at their original addresses, and updates the pointer to base−4N of the original transfer.
- R8: A high `mem_abort` while a write is presented cancels that write, pulses `faulted` on the next cycle, makes no pointer update, and leaves the resume register at the original mask and base−4 even when `cont_en`=1.
- R9: With `mode_lowlat`=1, a high `async_abort` stops the transfer before that cycle's write, pulses `faulted` and is never continuable; it takes priority over a simultaneous `irq`.
- R10: A start with an all-zero mask raises `done` in the next cycle with no memory write and no pointer update.
- R11: While `mem_ready` is low, the presented write, its address and its register index are held until the write is accepted.
- R12: `start` and `resume` are ignored while the block is busy.
- R13: `done`, `abandoned` and `faulted` are single-cycle pulses, and no two are high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (accepted when idle) |
| base_in | input | AW | Stack pointer value before the transfer |
| mask_in | input | NREG | Register selection, bit i selects register i |
| resume | input | 1 | Reload the transfer from the resume register (idle only) |
| mode_lowlat | input | 1 | 1 = low-latency interruptible mode, 0 = standard |
| cont_en | input | 1 | 1 = interrupt stops may be continued |
| irq | input | 1 | Interrupt request |
| async_abort | input | 1 | Asynchronous abort request |
| rf_rd_idx | output | log2(NREG) | Register-file read index |
| rf_rd_data | input | DW | Register-file read data for `rf_rd_idx` |
| mem_we | output | 1 | Word write request |
| mem_addr | output | AW | Word write address |
| mem_wdata | output | DW | Word write data |
| mem_ready | input | 1 | Memory accepts the presented write |
| mem_abort | input | 1 | Synchronous abort response for the presented write |
| sp_we | output | 1 | Stack pointer update strobe |
| sp_wdata | output | AW | New stack pointer value |
| busy | output | 1 | Transfer in progress or completing |
| done | output | 1 | Transfer completed pulse |
| abandoned | output | 1 | Interrupt stop pulse |
| faulted | output | 1 | Abort stop pulse |
| resume_mask | output | NREG | Mask held in the resume register |
| resume_addr | output | AW | Next address held in the resume register |

## Verification
The assertions check the per-cycle rules on every cycle. These are the 4-byte address step and the descending register index between consecutive writes, holding steady under a stall, and the pointer update occurring only with `done` and right after an accepted write. They also cover the stop cycle carrying no write, the single-cycle mutually exclusive status pulses, and a busy block ignoring a new start. Only the bench scenarios can show the whole-transfer results. These are the exact set of words stored and the final pointer value. They also include what the resume register holds after each kind of stop, and that a restart repeats the early words while a continuation does not.

// File: rtl/push_pkg.sv
package push_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int unsigned WORD_BYTES = 4;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_FIN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/push_pick.sv
// Selects the highest set bit of a register mask and returns the mask without it.
module push_pick #(
  parameter int unsigned NREG = 16,
  localparam int unsigned IW = $clog2(NREG)
) (
  input  logic [NREG-1:0] mask,
  output logic [IW-1:0]   idx,
  output logic [NREG-1:0] rest
);
  timeunit 1ns;
  timeprecision 100ps;

  always_comb begin
    idx = '0;
    for (int i = 0; i < NREG; i++) begin
      if (mask[i]) idx = IW'(i);
    end
    rest = mask;
    rest[idx] = 1'b0;
  end
endmodule

// File: rtl/push_resume_reg.sv
// Holds the point from which a stopped transfer is picked up again.
module push_resume_reg #(
  parameter int unsigned NREG = 16,
  parameter int unsigned AW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_full,
  input  logic [NREG-1:0] full_mask,
  input  logic [AW-1:0]   full_addr,
  input  logic            save_cur,
  input  logic [NREG-1:0] cur_mask,
  input  logic [AW-1:0]   cur_addr,
  output logic [NREG-1:0] res_mask,
  output logic [AW-1:0]   res_addr
);
  timeunit 1ns;
  timeprecision 100ps;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_mask <= '0;
      res_addr <= '0;
    end else if (load_full) begin
      res_mask <= full_mask;
      res_addr <= full_addr;
    end else if (save_cur) begin
      res_mask <= cur_mask;
      res_addr <= cur_addr;
    end
  end
endmodule

// File: rtl/push_multiple_seq.sv
module push_multiple_seq #(
  parameter int unsigned NREG = 16,
  parameter int unsigned AW   = 32,
  parameter int unsigned DW   = 32,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   base_in,
  input  logic [NREG-1:0] mask_in,
  input  logic            resume,
  input  logic            mode_lowlat,
  input  logic            cont_en,
  input  logic            irq,
  input  logic            async_abort,
  output logic [IW-1:0]   rf_rd_idx,
  input  logic [DW-1:0]   rf_rd_data,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_ready,
  input  logic            mem_abort,
  output logic            sp_we,
  output logic [AW-1:0]   sp_wdata,
  output logic            busy,
  output logic            done,
  output logic            abandoned,
  output logic            faulted,
  output logic [NREG-1:0] resume_mask,
  output logic [AW-1:0]   resume_addr
);
  timeunit 1ns;
  timeprecision 100ps;
  import push_pkg::*;

  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  function automatic logic [AW-1:0] top_slot(input logic [AW-1:0] b);
    return b - STEP;
  endfunction

  function automatic logic [AW-1:0] final_sp(input logic [AW-1:0] b,
                                             input logic [NREG-1:0] m);
    int unsigned n;
    n = 0;
    for (int i = 0; i < NREG; i++) n += int'(m[i]);
    return b - AW'(n * WORD_BYTES);
  endfunction

  seq_state_e      state;
  logic [NREG-1:0] cur_mask, omask_q, rest_mask;
  logic [AW-1:0]   cur_addr, base_q;
  logic            wb_pend, abandoned_q, faulted_q;

  // Named internal events
  logic run, stop_irq, stop_abort, sync_fault, wr_fire, seq_last;
  logic accept_start, accept_resume, save_cur;

  push_pick #(.NREG(NREG)) u_pick (
    .mask (cur_mask),
    .idx  (rf_rd_idx),
    .rest (rest_mask)
  );

  always_comb begin
    run           = (state == SEQ_RUN);
    stop_abort    = run && mode_lowlat && async_abort;
    stop_irq      = run && mode_lowlat && irq && !async_abort;
    mem_we        = run && !stop_abort && !stop_irq;
    sync_fault    = mem_we && mem_abort;
    wr_fire       = mem_we && mem_ready && !mem_abort;
    seq_last      = wr_fire && (rest_mask == '0);
    accept_start  = (state == SEQ_IDLE) && start;
    accept_resume = (state == SEQ_IDLE) && !start && resume;
    save_cur      = stop_irq && cont_en;
  end

  push_resume_reg #(.NREG(NREG), .AW(AW)) u_resume (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_full (accept_start),
    .full_mask (mask_in),
    .full_addr (top_slot(base_in)),
    .save_cur  (save_cur),
    .cur_mask  (cur_mask),
    .cur_addr  (cur_addr),
    .res_mask  (resume_mask),
    .res_addr  (resume_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= SEQ_IDLE;
      cur_mask    <= '0;
      cur_addr    <= '0;
      base_q      <= '0;
      omask_q     <= '0;
      wb_pend     <= 1'b0;
      abandoned_q <= 1'b0;
      faulted_q   <= 1'b0;
    end else begin
      abandoned_q <= 1'b0;
      faulted_q   <= 1'b0;
      unique case (state)
        SEQ_IDLE: begin
          if (accept_start) begin
            base_q   <= base_in;
            omask_q  <= mask_in;
            cur_mask <= mask_in;
            cur_addr <= top_slot(base_in);
            wb_pend  <= (mask_in != '0);
            state    <= (mask_in != '0) ? SEQ_RUN : SEQ_FIN;
          end else if (accept_resume) begin
            cur_mask <= resume_mask;
            cur_addr <= resume_addr;
            wb_pend  <= (resume_mask != '0);
            state    <= (resume_mask != '0) ? SEQ_RUN : SEQ_FIN;
          end
        end
        SEQ_RUN: begin
          if (stop_abort || sync_fault) begin
            faulted_q <= 1'b1;
            state     <= SEQ_IDLE;
          end else if (stop_irq) begin
            abandoned_q <= 1'b1;
            state       <= SEQ_IDLE;
          end else if (wr_fire) begin
            cur_mask <= rest_mask;
            cur_addr <= cur_addr - STEP;
            if (seq_last) state <= SEQ_FIN;
          end
        end
        SEQ_FIN: state <= SEQ_IDLE;
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign mem_addr  = cur_addr;
  assign mem_wdata = rf_rd_data;
  assign busy      = (state != SEQ_IDLE);
  assign done      = (state == SEQ_FIN);
  assign sp_we     = (state == SEQ_FIN) && wb_pend;
  assign sp_wdata  = final_sp(base_q, omask_q);
  assign abandoned = abandoned_q;
  assign faulted   = faulted_q;
endmodule

// File: rtl/push_seq_chk.sv
module push_seq_chk #(
  parameter int unsigned NREG = 16,
  parameter int unsigned AW   = 32,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [NREG-1:0] mask_in,
  input logic            mode_lowlat,
  input logic            mem_we,
  input logic            mem_ready,
  input logic            mem_abort,
  input logic [AW-1:0]   mem_addr,
  input logic [IW-1:0]   rf_rd_idx,
  input logic            sp_we,
  input logic            done,
  input logic            abandoned,
  input logic            faulted,
  input logic            busy,
  input logic            wr_fire,
  input logic            stop_irq,
  input logic            sync_fault,
  input logic [AW-1:0]   base_q
);
  timeunit 1ns;
  timeprecision 100ps;

  // R1
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire ##1 mem_we |-> mem_addr == $past(mem_addr) - AW'(4));

  // R2
  reg_descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire ##1 mem_we |-> rf_rd_idx < $past(rf_rd_idx));

  // R3
  sp_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we |-> done);

  // R3
  sp_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we |-> $past(wr_fire));

  // R4
  std_no_abandon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abandoned |-> $past(mode_lowlat));

  // R5
  stop_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_irq |-> !mem_we);

  // R5
  stop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_irq |=> abandoned && !sp_we);

  // R8
  fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_fault |=> faulted && !sp_we);

  // R10
  empty_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && mask_in == '0 |=> done && !sp_we);

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && !mem_ready && !mem_abort ##1 mem_we |-> $stable(mem_addr) && $stable(rf_rd_idx));

  // R12
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(base_q));

  // R13
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, abandoned, faulted}));

  // R13
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind push_multiple_seq push_seq_chk #(.NREG(NREG), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .mask_in     (mask_in),
  .mode_lowlat (mode_lowlat),
  .mem_we      (mem_we),
  .mem_ready   (mem_ready),
  .mem_abort   (mem_abort),
  .mem_addr    (mem_addr),
  .rf_rd_idx   (rf_rd_idx),
  .sp_we       (sp_we),
  .done        (done),
  .abandoned   (abandoned),
  .faulted     (faulted),
  .busy        (busy),
  .wr_fire     (wr_fire),
  .stop_irq    (stop_irq),
  .sync_fault  (sync_fault),
  .base_q      (base_q)
);

// File: tb/tb_push_multiple_seq.sv
module tb_push_multiple_seq;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, resume = 1'b0;
  logic [31:0] base_in = '0;
  logic [15:0] mask_in = '0;
  logic        mode_lowlat = 1'b0, cont_en = 1'b0, irq = 1'b0, async_abort = 1'b0;
  logic [3:0]  rf_rd_idx;
  logic [31:0] rf_rd_data;
  logic        mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ready = 1'b1, mem_abort = 1'b0;
  logic        sp_we;
  logic [31:0] sp_wdata;
  logic        busy, done, abandoned, faulted;
  logic [15:0] resume_mask;
  logic [31:0] resume_addr;

  always #2 clk = ~clk;  // 250 MHz

  function automatic logic [31:0] rfval(input int i);
    return 32'h5A00_0000 + 32'(i) * 32'h0001_0101;
  endfunction

  assign rf_rd_data = rfval(int'(rf_rd_idx));

  push_multiple_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_in(base_in), .mask_in(mask_in),
    .resume(resume), .mode_lowlat(mode_lowlat), .cont_en(cont_en), .irq(irq),
    .async_abort(async_abort), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_abort(mem_abort), .sp_we(sp_we), .sp_wdata(sp_wdata), .busy(busy), .done(done),
    .abandoned(abandoned), .faulted(faulted), .resume_mask(resume_mask),
    .resume_addr(resume_addr)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0, stall_en = 0;
  int wcount, spcount;
  logic [31:0] log_addr [64];
  logic [31:0] log_data [64];
  logic [31:0] sp_last;
  bit seen_done, seen_ab, seen_flt, s_any;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    wcount = 0; spcount = 0; sp_last = '0;
    seen_done = 0; seen_ab = 0; seen_flt = 0;
  endtask

  // Sample at the falling edge, then return just after the next rising edge.
  task automatic step();
    @(negedge clk);
    if (mem_we && mem_ready && !mem_abort && wcount < 64) begin
      log_addr[wcount] = mem_addr;
      log_data[wcount] = mem_wdata;
      wcount++;
    end
    if (sp_we) begin spcount++; sp_last = sp_wdata; end
    if (done) seen_done = 1;
    if (abandoned) seen_ab = 1;
    if (faulted) seen_flt = 1;
    s_any = done || abandoned || faulted;
    @(posedge clk);
    #1;
    cyc++;
    mem_ready = stall_en ? ((cyc % 3) != 2) : 1'b1;
  endtask

  task automatic wait_end();
    int n = 0;
    while (!(seen_done || seen_ab || seen_flt) && n < 200) begin step(); n++; end
    chk(n < 200, "R3 end of transfer seen", 32'(n), 32'd200);
    step();
    chk(!s_any, "R13 status pulse lasts one cycle", {31'd0, s_any}, 32'd0);
  endtask

  task automatic kick(input logic [31:0] b, input logic [15:0] m);
    clear_log();
    base_in = b; mask_in = m; start = 1;
    step();
    start = 0;
  endtask

  task automatic kick_resume();
    clear_log();
    resume = 1;
    step();
    resume = 0;
  endtask

  // Expected writes for base b / mask m, skipping the first `skip` selected registers.
  task automatic check_writes(input logic [31:0] b, input logic [15:0] m, input int skip);
    int k = 0, e = 0, tot = 0;
    for (int i = 0; i < 16; i++) tot += int'(m[i]);
    chk(wcount == tot - skip, "R1 word write count", 32'(wcount), 32'(tot - skip));
    for (int i = 15; i >= 0; i--) begin
      if (m[i]) begin
        k++;
        if (k > skip && e < wcount) begin
          chk(log_addr[e] == b - 32'(4 * k), "R1 write address", log_addr[e], b - 32'(4 * k));
          chk(log_data[e] == rfval(i), "R2 write data order", log_data[e], rfval(i));
          e++;
        end
      end
    end
  endtask

  task automatic wait_writes(input int n);
    int g = 0;
    while (wcount < n && g < 200) begin step(); g++; end
  endtask

  localparam int NV = 5;
  localparam logic [15:0] V_MASK [NV] = '{16'h01FF, 16'h8001, 16'hFFFF, 16'h0010, 16'hAAAA};
  localparam logic [31:0] V_BASE [NV] = '{32'h1000, 32'h2000, 32'h0400, 32'h0080, 32'h1_0000};
  localparam logic [31:0] V_SP   [NV] = '{32'h0FDC, 32'h1FF8, 32'h03C0, 32'h007C, 32'h0_FFE0};
  localparam bit          V_STD  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam bit          V_STALL[NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1};

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
      $finish;
    end
  end

  initial begin
    clear_log();
    repeat (3) step();
    rst_n = 1;
    step();
    chk(!busy && !mem_we && !done && !sp_we, "R13 reset idle outputs",
        {28'd0, busy, mem_we, done, sp_we}, 32'd0);
    chk(resume_mask == 16'h0 && resume_addr == 32'h0, "R6 reset resume register",
        {16'd0, resume_mask}, 32'd0);

    // Vector table: standard rows carry irq/async abort noise (R4), stall rows test R11.
    for (int v = 0; v < NV; v++) begin
      mode_lowlat = !V_STD[v];
      irq = V_STD[v]; async_abort = V_STD[v];
      stall_en = V_STALL[v];
      kick(V_BASE[v], V_MASK[v]);
      wait_end();
      irq = 0; async_abort = 0; stall_en = 0;
      check_writes(V_BASE[v], V_MASK[v], 0);
      chk(seen_done && !seen_ab && !seen_flt, "R4 R11 transfer completes",
          {29'd0, seen_done, seen_ab, seen_flt}, 32'd4);
      chk(spcount == 1 && sp_last == V_SP[v], "R3 pointer writeback", sp_last, V_SP[v]);
    end

    // R10 empty mask
    mode_lowlat = 1;
    kick(32'h0800, 16'h0000);
    step();
    chk(seen_done && wcount == 0 && spcount == 0, "R10 empty mask done",
        {30'd0, seen_done, 1'b0} | 32'(wcount + spcount), 32'd2);

    // R5 / R6 interrupt stop without continuation, then restart
    cont_en = 0;
    kick(32'h3000, 16'h00F0);
    wait_writes(2);
    irq = 1;
    wait_end();
    irq = 0;
    check_writes(32'h3000, 16'h00C0, 0);
    chk(seen_ab && !seen_done && spcount == 0, "R5 abandoned without writeback",
        {30'd0, seen_ab, seen_done} | 32'(spcount << 4), 32'd2);
    chk(resume_mask == 16'h00F0 && resume_addr == 32'h2FFC, "R6 resume holds restart point",
        {16'd0, resume_mask}, 32'h00F0);
    kick_resume();
    wait_end();
    check_writes(32'h3000, 16'h00F0, 0);
    chk(spcount == 1 && sp_last == 32'h2FF0, "R6 restart writeback", sp_last, 32'h2FF0);

    // R7 interrupt stop with continuation
    cont_en = 1;
    kick(32'h3000, 16'h00F0);
    wait_writes(2);
    irq = 1;
    wait_end();
    irq = 0;
    chk(seen_ab && wcount == 2, "R7 stopped after two words", 32'(wcount), 32'd2);
    chk(resume_mask == 16'h0030, "R7 remaining mask saved", {16'd0, resume_mask}, 32'h0030);
    chk(resume_addr == 32'h2FF4, "R7 next address saved", resume_addr, 32'h2FF4);
    kick_resume();
    wait_end();
    check_writes(32'h3000, 16'h00F0, 2);
    chk(spcount == 1 && sp_last == 32'h2FF0, "R7 continued writeback", sp_last, 32'h2FF0);

    // R8 synchronous abort is not continuable
    kick(32'h4000, 16'h0F00);
    wait_writes(2);
    mem_abort = 1;
    wait_end();
    mem_abort = 0;
    check_writes(32'h4000, 16'h0C00, 0);
    chk(seen_flt && !seen_ab && spcount == 0, "R8 faulted without writeback",
        {30'd0, seen_flt, seen_ab} | 32'(spcount << 4), 32'd2);
    chk(resume_mask == 16'h0F00 && resume_addr == 32'h3FFC, "R8 resume keeps restart point",
        {16'd0, resume_mask}, 32'h0F00);

    // R9 asynchronous abort wins over irq and is not continuable
    kick(32'h6000, 16'h000F);
    wait_writes(1);
    irq = 1; async_abort = 1;
    wait_end();
    irq = 0; async_abort = 0;
    chk(seen_flt && !seen_ab && wcount == 1 && spcount == 0, "R9 async abort faults",
        {30'd0, seen_flt, seen_ab}, 32'd2);
    chk(resume_mask == 16'h000F && resume_addr == 32'h5FFC, "R9 not continuable",
        {16'd0, resume_mask}, 32'h000F);

    // R12 start and resume ignored while busy
    mode_lowlat = 0; cont_en = 0;
    kick(32'h0500, 16'h000F);
    wait_writes(1);
    base_in = 32'h0900; mask_in = 16'hFFFF; start = 1; resume = 1;
    step();
    start = 0; resume = 0;
    wait_end();
    check_writes(32'h0500, 16'h000F, 0);
    chk(spcount == 1 && sp_last == 32'h04F0, "R12 busy start ignored", sp_last, 32'h04F0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule